// File: doc/BRIEF.md
# Capture/compare timer with sticky status flags

This block is one channel of a 16-bit timer. A counter advances by one on every clock and wraps from 0xFFFF to 0x0000. Four general registers, numbered 0 to 3, sit beside the counter. A per-channel mode bit sets each one up as a compare register or as a capture register. In compare mode a channel raises its event flag whenever the counter equals its general register. In capture mode a rising edge on the channel's capture input copies the counter into the general register and raises the flag. A fifth flag records counter overflow.

The flags are sticky. Software clears a flag by reading the status register while the flag is 1 and then writing 0 to that bit. A data-transfer controller can also clear channel flags through a strobe, unless its keep input holds them.

The counter, the mode register and the general registers are all reachable through one word-wide register port.

Top module: `capcmp_timer`

## Requirements
- R1: Register address 0 returns the status word. Bits 7 and 6 read 1, bit 5 reads 0, bit 4 is the overflow flag, bits 3..0 are the flags of channels 3..0, and bits 15..8 read 0. All flags are 0 after reset.
- R2: The counter (address 2) is 0 after reset and increments by one on every clock, wrapping to 0. A write to address 2 loads the written value in place of the increment.
- R3: The overflow flag (status bit 4) sets in the cycle the counter steps from 0xFFFF to 0x0000. A counter write issued while the counter holds 0xFFFF does not set it.
- R4: A channel whose mode bit is 0 (compare) sets its flag in every cycle where the counter equals its general register.
- R5: A channel whose mode bit is 1 (capture) sees its capture input through a two-flop synchronizer. A rising edge loads the counter value of that cycle into the general register and sets the flag. The flag becomes visible two clocks after the edge that first samples the input high.
- R6: Writing 0 to a status bit clears that flag only if the most recent status read, with no status write in between, returned it as 1. Writing 1 never clears a flag, and writing 0 with no such prior read has no effect.
- R7: A status write consumes every read marker, so a second write of 0 without a new read clears nothing.
- R8: Asserting xfer_act_i[n] clears channel n's flag when xfer_keep_i is 0, and has no effect when xfer_keep_i is 1. The overflow flag is never cleared this way.
- R9: When a flag's set condition and any clear condition occur in the same cycle, the flag ends up set.
- R10: Address 1 holds the mode bits (bit n = 1 selects capture for channel n). Addresses 4..7 hold general registers 0..3 and can be written and read back. A capture takes priority over a same-cycle write. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read, qualified by bus_sel_i |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| cap_i | input | 4 | Asynchronous capture levels, one per channel |
| xfer_act_i | input | 4 | Transfer-controller activation strobe, one per channel |
| xfer_keep_i | input | 1 | 1 = activation leaves the flags unchanged |

## Verification
The checker assumes that reset is asserted from time zero and that every input holds a defined 0 or 1 at each clock edge. It also assumes that a read of the status word and a write to it never fall in the same cycle, which holds because bus_wr_i selects one or the other. It makes no assumption about how capture edges line up with clears or counter writes. The stimulus therefore drives every input only at the falling clock edge. It covers both directed coincidences, such as a capture edge landing on a software clear or a transfer strobe, and a long stretch of random register traffic with toggling capture inputs.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
    localparam int unsigned CNT_W    = 16;
    localparam int unsigned NUM_CH   = 4;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned CH_W     = $clog2(NUM_CH);
    localparam int unsigned NUM_FLAG = NUM_CH + 1;
    localparam int unsigned OVF_IDX  = NUM_CH;

    localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_GR0  = 3'd4;

    typedef struct packed {
        logic [CNT_W-1:0]              cnt;
        logic [NUM_CH-1:0][CNT_W-1:0]  gr;
        logic [NUM_CH-1:0]             mode;
    } core_t;
endpackage

// File: rtl/capcmp_edge.sv
module capcmp_edge #(
    parameter int unsigned W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = lvl_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.prev;
endmodule

// File: rtl/capcmp_flag.sv
module capcmp_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic arm_i,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic xclr_i,
    output logic flag_o,
    output logic armed_o
);
    typedef struct packed {
        logic flag;
        logic armed;
    } cell_t;

    cell_t st_d, st_q;
    logic  clr;

    always_comb begin
        st_d = st_q;
        clr  = (wr_i && st_q.armed && !wbit_i) || xclr_i;
        // set dominates any clear in the same cycle
        st_d.flag = set_i || (st_q.flag && !clr);
        if (arm_i)     st_d.armed = st_q.flag;
        else if (wr_i) st_d.armed = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o  = st_q.flag;
    assign armed_o = st_q.armed;
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import capcmp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    input  logic [NUM_CH-1:0] cap_i,
    input  logic [NUM_CH-1:0] xfer_act_i,
    input  logic              xfer_keep_i
);
    core_t st_d, st_q;

    logic                         acc_rd, acc_wr;
    logic                         stat_rd, stat_wr, cnt_wr, gr_hit;
    logic [CH_W-1:0]              gr_idx;
    logic [NUM_CH-1:0]            rise_w;
    logic [NUM_FLAG-1:0]          set_w, xclr_w, flag_w, armed_w;
    logic [CNT_W-1:0]             cnt_w;
    logic [NUM_CH-1:0][CNT_W-1:0] gr_w;
    logic [NUM_CH-1:0]            mode_w;

    assign acc_rd  = bus_sel_i && !bus_wr_i;
    assign acc_wr  = bus_sel_i && bus_wr_i;
    assign stat_rd = acc_rd && (bus_addr_i == A_STAT);
    assign stat_wr = acc_wr && (bus_addr_i == A_STAT);
    assign cnt_wr  = acc_wr && (bus_addr_i == A_CNT);
    assign gr_hit  = bus_addr_i >= A_GR0;
    assign gr_idx  = bus_addr_i[CH_W-1:0];

    assign cnt_w  = st_q.cnt;
    assign gr_w   = st_q.gr;
    assign mode_w = st_q.mode;

    capcmp_edge #(.W(NUM_CH)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (cap_i),
        .rise_o (rise_w)
    );

    // event sources per flag
    always_comb begin
        set_w  = '0;
        xclr_w = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            set_w[ch]  = st_q.mode[ch] ? rise_w[ch] : (st_q.cnt == st_q.gr[ch]);
            xclr_w[ch] = xfer_act_i[ch] && !xfer_keep_i;
        end
        set_w[OVF_IDX] = (st_q.cnt == '1) && !cnt_wr;
    end

    // next-state of counter, general and mode registers
    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_wr ? bus_wdata_i : st_q.cnt + 1'b1;
        if (acc_wr && (bus_addr_i == A_MODE)) st_d.mode = bus_wdata_i[NUM_CH-1:0];
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (st_q.mode[ch] && rise_w[ch])
                st_d.gr[ch] = st_q.cnt;
            else if (acc_wr && gr_hit && (gr_idx == CH_W'(ch)))
                st_d.gr[ch] = bus_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
        capcmp_flag u_flag (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .set_i   (set_w[f]),
            .arm_i   (stat_rd),
            .wr_i    (stat_wr),
            .wbit_i  (bus_wdata_i[f]),
            .xclr_i  (xclr_w[f]),
            .flag_o  (flag_w[f]),
            .armed_o (armed_w[f])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        if (gr_hit) begin
            bus_rdata_o = st_q.gr[gr_idx];
        end else begin
            case (bus_addr_i)
                A_STAT:  bus_rdata_o[7:0] = {3'b110, flag_w};
                A_MODE:  bus_rdata_o[NUM_CH-1:0] = st_q.mode;
                A_CNT:   bus_rdata_o = st_q.cnt;
                default: bus_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk
    import capcmp_pkg::*;
(
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         sel_i,
    input logic                         wr_i,
    input logic [ADDR_W-1:0]            addr_i,
    input logic [NUM_FLAG-1:0]          wdata_i,
    input logic [CNT_W-1:NUM_FLAG]      rdata_i,
    input logic [CNT_W-1:0]             cnt_i,
    input logic [NUM_CH-1:0][CNT_W-1:0] gr_i,
    input logic [NUM_CH-1:0]            mode_i,
    input logic [NUM_FLAG-1:0]          flag_i,
    input logic [NUM_FLAG-1:0]          armed_i,
    input logic [NUM_CH-1:0]            rise_i,
    input logic [NUM_CH-1:0]            xact_i,
    input logic                         keep_i
);
    logic swr, cwr;
    assign swr = sel_i && wr_i && (addr_i == A_STAT);
    assign cwr = sel_i && wr_i && (addr_i == A_CNT);

    AST_STATUS_FMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == A_STAT) |-> (rdata_i == 11'b000_0000_0110)) else $error("status format"); // R1

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(cwr)) |-> (cnt_i == $past(cnt_i) + 16'd1)) else $error("counter step"); // R2

    AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni && (cnt_i == 16'hFFFF) && !cwr) |-> flag_i[OVF_IDX]) else $error("overflow flag"); // R3

    AST_OVF_CLR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag_i[OVF_IDX]) |-> $past(swr && armed_i[OVF_IDX] && !wdata_i[OVF_IDX])) else $error("overflow clear"); // R6

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        AST_CMP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni && !mode_i[g] && (cnt_i == gr_i[g])) |-> flag_i[g]) else $error("compare set"); // R4

        AST_CAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni && mode_i[g] && rise_i[g]) |-> (flag_i[g] && (gr_i[g] == $past(cnt_i)))) else $error("capture load"); // R5

        AST_CLR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(flag_i[g]) |-> ($past(swr && armed_i[g] && !wdata_i[g]) || $past(xact_i[g] && !keep_i))) else $error("flag clear source"); // R8
    end
endmodule

bind capcmp_timer capcmp_timer_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (bus_sel_i),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i[capcmp_pkg::NUM_FLAG-1:0]),
    .rdata_i (bus_rdata_o[capcmp_pkg::CNT_W-1:capcmp_pkg::NUM_FLAG]),
    .cnt_i   (cnt_w),
    .gr_i    (gr_w),
    .mode_i  (mode_w),
    .flag_i  (flag_w),
    .armed_i (armed_w),
    .rise_i  (rise_w),
    .xact_i  (xfer_act_i),
    .keep_i  (xfer_keep_i)
);

// File: tb/capcmp_timer_tb_top.sv
`timescale 1ns/1ps
module capcmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  cap = '0, xact = '0;
    logic        keep = 1'b0;

    // values applied at the next falling edge
    logic [3:0]  n_cap = '0, n_xact = '0;
    logic        n_keep = 1'b0;

    int vectors = 0;
    int fails = 0;
    int cycle = 0;
    string tag = "R1";

    // behavioural reference state
    logic [15:0] m_cnt = '0;
    logic [15:0] m_gr [4] = '{default: '0};
    logic [3:0]  m_mode = '0;
    logic [4:0]  m_flag = '0, m_mark = '0;
    logic [3:0]  m_s1 = '0, m_s2 = '0, m_p = '0;

    always #4 clk = ~clk;

    capcmp_timer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .cap_i       (cap),
        .xfer_act_i  (xact),
        .xfer_keep_i (keep)
    );

    function automatic logic [15:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0:    return {8'h00, 3'b110, m_flag};
            3'd1:    return {12'h000, m_mode};
            3'd2:    return m_cnt;
            3'd3:    return 16'h0000;
            default: return m_gr[a - 3'd4];
        endcase
    endfunction

    task automatic m_step();
        logic [3:0]  edg;
        logic [15:0] oc;
        logic [4:0]  setv, clrv;
        logic        cwr, swr, srd;
        edg  = m_s2 & ~m_p;
        oc   = m_cnt;
        cwr  = sel && wr && addr == 3'd2;
        swr  = sel && wr && addr == 3'd0;
        srd  = sel && !wr && addr == 3'd0;
        setv = '0;
        clrv = swr ? (m_mark & ~wdata[4:0]) : 5'b0;
        setv[4] = (oc == 16'hFFFF) && !cwr;
        for (int i = 0; i < 4; i++) begin
            setv[i] = m_mode[i] ? edg[i] : (oc == m_gr[i]);
            if (xact[i] && !keep) clrv[i] = 1'b1;
        end
        if (srd)      m_mark = m_flag;
        else if (swr) m_mark = '0;
        m_flag = setv | (m_flag & ~clrv);
        for (int i = 0; i < 4; i++) begin
            if (m_mode[i] && edg[i])                      m_gr[i] = oc;
            else if (sel && wr && addr == 3'(4 + i))      m_gr[i] = wdata;
        end
        if (sel && wr && addr == 3'd1) m_mode = wdata[3:0];
        m_cnt = cwr ? wdata : oc + 16'd1;
        m_p  = m_s2;
        m_s2 = m_s1;
        m_s1 = cap;
    endtask

    // one bus cycle: drive at falling edge, compare, step model at rising edge
    task automatic cyc(input logic s, input logic w, input logic [2:0] a, input logic [15:0] d);
        logic [15:0] exp;
        sel = s; wr = w; addr = a; wdata = d;
        cap = n_cap; xact = n_xact; keep = n_keep;
        #1;
        exp = m_rd(a);
        vectors++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d addr %0d: got %h expected %h", tag, cycle, a, rdata, exp);
        end
        @(posedge clk);
        m_step();
        cycle++;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic [2:0] a);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, a, 16'h0);
    endtask

    task automatic rd(input logic [2:0] a);
        cyc(1'b1, 1'b0, a, 16'h0);
    endtask

    task automatic wrr(input logic [2:0] a, input logic [15:0] d);
        cyc(1'b1, 1'b1, a, d);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        tag = "R1"; idle(1, 3'd0);           // reset state of the status word
        tag = "R4"; idle(3, 3'd0);           // counter 0 equals reset registers
        tag = "R2"; idle(4, 3'd2);           // counter increments
        tag = "R10";
        wrr(3'd4, 16'h0040); wrr(3'd5, 16'h0050); wrr(3'd6, 16'h0060); wrr(3'd7, 16'h0070);
        rd(3'd4); rd(3'd5); rd(3'd6); rd(3'd7); rd(3'd3); rd(3'd1);

        tag = "R6"; wrr(3'd0, 16'h0000); rd(3'd0);   // no prior read: no clear
        rd(3'd0); wrr(3'd0, 16'h001F); rd(3'd0);      // write of 1s: no clear
        tag = "R7"; wrr(3'd0, 16'h0000); rd(3'd0);   // marker already consumed
        tag = "R6"; rd(3'd0); wrr(3'd0, 16'h0000); idle(2, 3'd0);
        tag = "R4"; idle(120, 3'd0);                  // pass all four compare values

        tag = "R2"; wrr(3'd2, 16'hFFF8); rd(3'd2);
        tag = "R3"; idle(12, 3'd0);
        rd(3'd0); wrr(3'd0, 16'h0000);
        wrr(3'd2, 16'hFFFE); idle(1, 3'd2); wrr(3'd2, 16'h0100); idle(3, 3'd0);

        tag = "R5";
        rd(3'd0); wrr(3'd0, 16'h0000);
        wrr(3'd1, 16'h000A);
        n_cap = 4'b0010; idle(6, 3'd5);
        n_cap = 4'b0000; idle(3, 3'd0); rd(3'd5);
        n_cap = 4'b1000; idle(5, 3'd7);
        n_cap = 4'b0000; idle(3, 3'd7);

        tag = "R8";
        n_keep = 1'b1; n_xact = 4'b1111; idle(2, 3'd0);
        n_keep = 1'b0; idle(2, 3'd0);
        n_xact = 4'b0000; idle(2, 3'd0);

        tag = "R9";
        n_cap = 4'b0010; idle(4, 3'd0); n_cap = 4'b0000; idle(3, 3'd0);  // flag B set
        n_cap = 4'b0010; rd(3'd0); idle(1, 3'd0); wrr(3'd0, 16'h0000); idle(2, 3'd0);
        n_cap = 4'b0000; idle(3, 3'd0);
        n_cap = 4'b1000; n_xact = 4'b1000; idle(5, 3'd0);
        n_cap = 4'b0000; n_xact = 4'b0000; idle(2, 3'd0);

        tag = "R9";
        for (int i = 0; i < 2500; i++) begin
            logic [2:0] a;
            logic [15:0] d;
            int k;
            k = $urandom_range(0, 99);
            a = 3'($urandom_range(0, 7));
            d = 16'($urandom);
            if ($urandom_range(0, 7) == 0) n_cap = 4'($urandom);
            n_xact = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0000;
            n_keep = 1'($urandom);
            if (a == 3'd2 && k < 90) a = 3'd0;
            if (k < 40)      cyc(1'b1, 1'b0, a, 16'h0);
            else if (k < 60) cyc(1'b1, 1'b1, a, d);
            else             cyc(1'b0, 1'b0, a, 16'h0);
        end
        n_cap = '0; n_xact = '0; n_keep = 1'b0;
        idle(2, 3'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule